// File: doc/BRIEF.md
# Two-Slot Elastic Relay Station

This block is one registered segment of a latency-insensitive channel. A sender on the upstream side offers a data word together with a valid flag. The block answers with a stop flag. On the downstream side the block offers a word and a valid flag, and it receives a stop flag from the next stage or from the consumer. A long wire between a sender and a receiver is split by placing a chain of these stages along it. Each stage adds one cycle of latency. Tokens keep their order, and none is lost or repeated.

The stage has two slots. The main slot always drives the downstream outputs. The auxiliary slot catches the one token that is already on its way in during the cycle a downstream stall appears. The upstream stop output is a register bit that shows whether the auxiliary slot is occupied. Because of this, a stall spreads upstream one stage per clock and never forms a combinational path through a chain. While nothing stalls, the stage passes one token per cycle. When a stall clears, full rate resumes without an inserted bubble.

Top module: `elastic_relay_station`

## Requirements
- R1: After a synchronous active-high reset, `dn_valid` is 0 and `up_stop` is 0.
- R2: A word is accepted at a rising edge when `up_valid` is 1 and `up_stop` is 0 at that edge. If the stage was empty, or its main token leaves at the same edge, the word appears on `dn_data` with `dn_valid` = 1 right after that edge.
- R3: A cycle with `up_valid` = 0 is a bubble. Its `up_data` is not stored, and it changes neither `dn_data` nor `dn_valid` nor `up_stop`.
- R4: While `dn_valid` = 1 and `dn_stop` = 1 at an edge, `dn_valid` stays 1 and `dn_data` is unchanged after that edge.
- R5: If the main slot holds a token, the auxiliary slot is empty, `dn_stop` is 1, and a word is accepted, then that word goes to the auxiliary slot and `up_stop` becomes 1 after the edge.
- R6: `up_stop` changes only at rising edges. It never follows a change of `dn_stop` within a cycle, and it is 1 exactly while the auxiliary slot is occupied.
- R7: While `up_stop` is 1, the word on `up_data` is not accepted, even if `up_valid` is 1.
- R8: When both slots are full and `dn_stop` is 0 at an edge, the main token is delivered, the auxiliary token moves to `dn_data`, and `up_stop` returns to 0 after that edge.
- R9: The words delivered downstream (`dn_valid` = 1 and `dn_stop` = 0 at an edge) are exactly the accepted words, in the same order. With `up_valid` held at 1 and `dn_stop` held at 0, one word is delivered every cycle.
- R10: A reset asserted while both slots are full empties both slots in the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | DATA_W | Word offered by the sender |
| up_valid | input | 1 | The offered word is a real token |
| up_stop | output | 1 | Registered back-pressure to the sender |
| dn_data | output | DATA_W | Word from the main slot |
| dn_valid | output | 1 | The main slot holds a token |
| dn_stop | input | 1 | Back-pressure from the receiver |

## Verification
Two transfers can happen at the same edge. One is the delivery of the main token downstream. The other is a refill of the main slot, either from `up_data` when only one slot is full, or from the auxiliary slot when both are full, which also releases `up_stop`. The vector table drives `up_valid` = 1 with `dn_stop` = 0 in both the one-slot and the two-slot state, and judges the result from the word that appears on `dn_data` and the `up_stop` value after the edge. A long stream with pseudo-random valid and stop patterns then compares every delivered word against a queue of the accepted words, so a dropped, repeated or reordered word on such an edge is caught.

// File: rtl/ers_pkg.sv
package ers_pkg;

    // Occupancy of the stage: bit 0 = main slot full, bit 1 = aux slot full.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_ONE   = 2'b01,
        OCC_TWO   = 2'b11
    } occ_e;

    // Where the main slot loads from at the coming edge.
    typedef enum logic [1:0] {
        MSRC_HOLD  = 2'd0,
        MSRC_INPUT = 2'd1,
        MSRC_AUX   = 2'd2
    } msrc_e;

    typedef struct packed {
        msrc_e main_src;
        logic  aux_load;
    } slot_ctl_t;

endpackage

// File: rtl/ers_ctrl.sv
module ers_ctrl
    import ers_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      up_valid,
    input  logic      dn_stop,
    output slot_ctl_t ctl,
    output logic      main_full,
    output logic      aux_full
);

    typedef struct packed {
        occ_e occ;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        take, give;

    always_comb begin
        st_d         = st_q;
        ctl.main_src = MSRC_HOLD;
        ctl.aux_load = 1'b0;
        take         = up_valid && (st_q.occ != OCC_TWO);
        give         = (st_q.occ != OCC_EMPTY) && !dn_stop;
        unique case (st_q.occ)
            OCC_EMPTY: begin
                if (take) begin
                    st_d.occ     = OCC_ONE;
                    ctl.main_src = MSRC_INPUT;
                end
            end
            OCC_ONE: begin
                unique case ({take, give})
                    2'b10: begin
                        st_d.occ     = OCC_TWO;
                        ctl.aux_load = 1'b1;
                    end
                    2'b01: st_d.occ = OCC_EMPTY;
                    2'b11: ctl.main_src = MSRC_INPUT;
                    default: ;
                endcase
            end
            OCC_TWO: begin
                if (give) begin
                    st_d.occ     = OCC_ONE;
                    ctl.main_src = MSRC_AUX;
                end
            end
            default: st_d.occ = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{occ: OCC_EMPTY};
        else     st_q <= st_d;
    end

    assign main_full = st_q.occ[0];
    assign aux_full  = st_q.occ[1];

    AST_AUX_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst)
        aux_full |-> main_full);                                          // R5
    AST_STALL_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (rst)
        (main_full && dn_stop) |=> main_full);                            // R4
    AST_CATCH_IN_AUX: assert property (@(posedge clk) disable iff (rst)
        (main_full && !aux_full && dn_stop && up_valid) |=> aux_full);    // R5
    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (aux_full && dn_stop) |=> aux_full);                              // R7
    AST_AUX_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (aux_full && !dn_stop) |=> (main_full && !aux_full));             // R8
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (main_full && !aux_full && !dn_stop && up_valid) |=> (main_full && !aux_full)); // R9
    AST_BUBBLE_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (!main_full && !up_valid) |=> !main_full);                        // R3

endmodule

// File: rtl/ers_slots.sv
module ers_slots
    import ers_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_ctl_t         ctl,
    input  logic [DATA_W-1:0] up_data,
    input  logic              main_full,
    input  logic              dn_stop,
    output logic [DATA_W-1:0] main_data
);

    typedef struct packed {
        logic [DATA_W-1:0] main_w;
        logic [DATA_W-1:0] aux_w;
    } slot_state_t;

    slot_state_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        unique case (ctl.main_src)
            MSRC_INPUT: sl_d.main_w = up_data;
            MSRC_AUX:   sl_d.main_w = sl_q.aux_w;
            default:    ;
        endcase
        if (ctl.aux_load) sl_d.aux_w = up_data;
    end

    always_ff @(posedge clk) begin
        if (rst) sl_q <= '0;
        else     sl_q <= sl_d;
    end

    assign main_data = sl_q.main_w;

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (main_full && dn_stop) |=> $stable(main_data));                   // R4

    always_comb begin
        if (!rst && ctl.aux_load)
            AST_ONE_TARGET: assert (ctl.main_src == MSRC_HOLD);           // R5
    end

endmodule

// File: rtl/elastic_relay_station.sv
module elastic_relay_station
    import ers_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_valid,
    output logic              up_stop,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_valid,
    input  logic              dn_stop
);

    slot_ctl_t ctl;
    logic      main_full;
    logic      aux_full;

    ers_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .up_valid  (up_valid),
        .dn_stop   (dn_stop),
        .ctl       (ctl),
        .main_full (main_full),
        .aux_full  (aux_full)
    );

    ers_slots #(.DATA_W(DATA_W)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .up_data   (up_data),
        .main_full (main_full),
        .dn_stop   (dn_stop),
        .main_data (dn_data)
    );

    assign dn_valid = main_full;
    assign up_stop  = aux_full;

    AST_STOP_SETTLED: assert property (@(posedge clk) disable iff (rst)
        (!up_stop && up_valid && dn_valid && dn_stop) |=> up_stop);       // R6
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (!dn_valid && up_valid && !up_stop) |=> (dn_valid && dn_data == $past(up_data))); // R2

endmodule

// File: tb/test_elastic_relay_station.sv
`timescale 1ns/1ps
module test_elastic_relay_station;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] up_data = '0;
    logic         up_valid = 1'b0;
    logic         up_stop;
    logic [W-1:0] dn_data;
    logic         dn_valid;
    logic         dn_stop = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    elastic_relay_station #(.DATA_W(W)) i_elastic_relay_station (
        .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid),
        .up_stop(up_stop), .dn_data(dn_data), .dn_valid(dn_valid), .dn_stop(dn_stop)
    );

    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
        logic         s;
        logic         edv;
        logic [W-1:0] edd;
        logic         eus;
    } vec_t;

    // Inputs before an edge, expected outputs after it (edd ignored when edv = 0).
    localparam vec_t VEC [14] = '{
        '{1'b1, 16'h1001, 1'b0, 1'b1, 16'h1001, 1'b0},  // R2 fill from empty
        '{1'b1, 16'h1002, 1'b0, 1'b1, 16'h1002, 1'b0},  // R9 take and give
        '{1'b1, 16'h1003, 1'b1, 1'b1, 16'h1002, 1'b1},  // R5 catch in aux
        '{1'b1, 16'h1004, 1'b1, 1'b1, 16'h1002, 1'b1},  // R7 refused while full
        '{1'b1, 16'h1004, 1'b0, 1'b1, 16'h1003, 1'b0},  // R8 aux to main
        '{1'b1, 16'h1004, 1'b0, 1'b1, 16'h1004, 1'b0},  // R9 no bubble
        '{1'b0, 16'h00FF, 1'b0, 1'b0, 16'h0000, 1'b0},  // R3 bubble, drain
        '{1'b0, 16'h00EE, 1'b1, 1'b0, 16'h0000, 1'b0},  // R3 empty stays empty
        '{1'b1, 16'h1005, 1'b1, 1'b1, 16'h1005, 1'b0},  // R2 fill while stopped
        '{1'b0, 16'h0077, 1'b1, 1'b1, 16'h1005, 1'b0},  // R3 bubble ignored, R4 hold
        '{1'b1, 16'h1006, 1'b1, 1'b1, 16'h1005, 1'b1},  // R5
        '{1'b1, 16'h1007, 1'b0, 1'b1, 16'h1006, 1'b1 & 1'b0}, // R8, R7 1007 refused
        '{1'b1, 16'h1007, 1'b0, 1'b1, 16'h1007, 1'b0},  // R9
        '{1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}   // R3 drain
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] d, input logic s);
        up_valid = v;
        up_data  = d;
        dn_stop  = s;
    endtask

    logic [15:0] lf_src = 16'hACE1;
    logic [15:0] lf_stp = 16'h5A3C;

    function automatic logic [15:0] step(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] q[$];
        logic         src_v;
        logic [W-1:0] src_d;
        logic [W-1:0] seq;
        logic         acc;
        logic         del;
        int           sent;
        int           got;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 dn_valid", dn_valid, 0);
        chk("R1 up_stop", up_stop, 0);

        // Vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            drive(VEC[i].v, VEC[i].d, VEC[i].s);
            @(posedge clk);
            #1;
            chk("R2/R9 vec dn_valid", dn_valid, VEC[i].edv);
            chk("R6 vec up_stop", up_stop, VEC[i].eus);
            if (VEC[i].edv) chk("R4/R8 vec dn_data", dn_data, VEC[i].edd);
        end

        // R6: up_stop ignores dn_stop changes within a cycle (one slot full)
        @(negedge clk); drive(1'b1, 16'h2001, 1'b1);
        @(negedge clk); drive(1'b0, 16'h0000, 1'b1);
        #0.5; dn_stop = 1'b0; #0.3;
        chk("R6 stop no comb path", up_stop, 0);
        dn_stop = 1'b1; #0.3;
        chk("R6 stop no comb path", up_stop, 0);
        // fill aux, then drop dn_stop mid-cycle: up_stop stays until edge
        @(negedge clk); drive(1'b1, 16'h2002, 1'b1);
        @(negedge clk); drive(1'b0, 16'h0000, 1'b1);
        #0.2;
        chk("R5 aux caught", up_stop, 1);
        dn_stop = 1'b0; #0.5;
        chk("R6 stop held in cycle", up_stop, 1);
        @(posedge clk); #1;
        chk("R8 stop released", up_stop, 0);
        chk("R8 aux forwarded", dn_data, 16'h2002);

        // R10 reset with both slots full
        @(negedge clk); drive(1'b1, 16'h3001, 1'b1);
        @(negedge clk); drive(1'b1, 16'h3002, 1'b1);
        @(negedge clk); drive(1'b1, 16'h3003, 1'b1);
        #0.2;
        chk("R10 precondition full", up_stop, 1);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R10 dn_valid cleared", dn_valid, 0);
        chk("R10 up_stop cleared", up_stop, 0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 16'h0000, 1'b0);

        // R9 full throughput with no stalls
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            drive(1'b1, 16'h5000 + W'(i), 1'b0);
            #1;
            chk("R9 never stopped", up_stop, 0);
            if (i >= 1) begin
                chk("R9 one per cycle", dn_valid, 1);
                chk("R9 order at rate", dn_data, 16'h5000 + W'(i - 1));
            end
        end
        @(negedge clk); drive(1'b0, 16'h0000, 1'b0);
        @(negedge clk);

        // R9 / R7 stream with random valid and stop
        src_v = 1'b0; src_d = '0; seq = 16'h8000; acc = 1'b0;
        sent = 0; got = 0;
        for (int c = 0; c < 420; c++) begin
            @(negedge clk);
            if (!src_v || acc) begin
                lf_src = step(lf_src);
                src_v  = (c < 380) && (lf_src[0] | lf_src[3]);
                if (src_v) begin
                    src_d = seq;
                    seq   = seq + 1'b1;
                end
            end
            lf_stp = step(lf_stp);
            drive(src_v, src_v ? src_d : 16'hDEAD, (c < 380) && lf_stp[5] && lf_stp[2]);
            #1;
            acc = up_valid && !up_stop;
            del = dn_valid && !dn_stop;
            if (del) begin
                got++;
                if (q.size() == 0) chk("R9 spurious token", 1, 0);
                else chk("R9 stream order", dn_data, q.pop_front());
            end
            if (acc) begin
                q.push_back(src_d);
                sent++;
            end
        end
        chk("R9 nothing left", q.size(), 0);
        chk("R9 count", got, sent);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule